// File: doc/BRIEF.md
# NRZI Packet Receiver with Bit Unstuffing

This block sits behind a line monitor that has already recovered bit timing. Each clock cycle in which `sym_valid_i` is high carries one line symbol, sampled at the centre of a bit period. The block tracks the line state and detects the start of a packet. It turns the NRZI-coded symbols into data bits and drops the stuffed zeros the transmitter inserted. It also recognises the single-ended-zero sequence that closes a packet.

All results are registered and appear one clock after the symbol that caused them. Decoded bits leave as `bit_o` qualified by `bit_valid_o`. Framing and error events are single-cycle pulses. When a packet starts with the synchronisation pattern followed by the preamble identifier, the block closes the packet and pulses a request. An upstream controller uses that request to switch the line monitor to low-rate timing with full-rate polarity. Timing recovery, identifier checks and CRC checks are left to the neighbouring blocks.

Top module: `nrzi_rx_top`

## Requirements
- R1: Symbols on `sym_i` are coded 2'b00 single-ended zero (SE0), 2'b01 J, 2'b10 K, 2'b11 single-ended one (SE1). In the idle state, a valid K pulses `sop_o` one clock later. The idle state is entered after a J has been received in the wait-for-idle state.
- R2: The K that starts a packet is delivered as data bit 0. Each following J or K delivers a 1 when it equals the previous line symbol and a 0 when it differs. The bit appears on `bit_o` with `bit_valid_o` one clock later.
- R3: After six consecutive decoded 1s, a following 0 is a stuff bit. It produces no `bit_valid_o`, and the ones count restarts from zero.
- R4: After six consecutive decoded 1s, a following 1 pulses `stuff_err_o` without `bit_valid_o`, and the packet is abandoned.
- R5: Any delivered 0 bit restarts the ones count, so six ones are needed again before a stuff bit is expected.
- R6: An SE0 during a packet produces no data and begins end of packet. Further SE0 symbols keep it open. A J then pulses `eop_o`.
- R7: Inside an open end of packet, a K or an SE1 pulses `eop_err_o`.
- R8: Consider the first 16 delivered bits of a packet, counting the start bit and not counting stuff bits, with the first received bit leftmost. When they equal 0000000100111100, `pre_req_o` pulses together with the sixteenth bit and the packet ends.
- R9: After reset, and after any end of packet, error or preamble request, the block waits for a J before another K can start a packet.
- R10: Cycles with `sym_valid_i` low change nothing. Every output is low in any cycle that does not follow a valid symbol.
- R11: An SE1 received while bits are being collected pulses `eop_err_o` and abandons the packet. An SE0 or SE1 received while idle returns the block to waiting for idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_valid_i | input | 1 | A line symbol is present this cycle |
| sym_i | input | 2 | Line symbol code |
| bit_o | output | 1 | Decoded data bit |
| bit_valid_o | output | 1 | `bit_o` carries a data bit |
| sop_o | output | 1 | Start-of-packet pulse |
| eop_o | output | 1 | Valid end-of-packet pulse |
| stuff_err_o | output | 1 | Bit-stuffing violation pulse |
| eop_err_o | output | 1 | Malformed end-of-packet or SE1 pulse |
| pre_req_o | output | 1 | Low-rate-after-preamble request pulse |

## Verification
The assertions assume that `sym_i` is only meaningful in cycles where `sym_valid_i` is high. They relate each output pulse to the valid symbol one cycle before it, so they take it for granted that the line monitor never delivers two symbols for a single bit period. The stimulus always drives a defined symbol code with each valid strobe. It fills the idle cycles between symbols with random codes, which shows that those codes have no effect. Symbol streams are built from intended bit sequences through an NRZI encoder in the bench, so stuffing and preamble patterns land exactly where they are meant to.

// File: rtl/nrzi_rx_pkg.sv
package nrzi_rx_pkg;

  typedef enum logic [1:0] {
    SYM_SE0 = 2'b00,
    SYM_J   = 2'b01,
    SYM_K   = 2'b10,
    SYM_SE1 = 2'b11
  } line_sym_e;

  typedef enum logic [1:0] {
    ST_WAIT_IDLE = 2'd0,
    ST_IDLE      = 2'd1,
    ST_BITS      = 2'd2,
    ST_EOP       = 2'd3
  } rx_state_e;

  typedef struct packed {
    logic data;
    logic data_vld;
    logic sop;
    logic eop;
    logic stuff_err;
    logic eop_err;
    logic pre_req;
  } rx_out_t;

endpackage

// File: rtl/nrzi_unstuff.sv
module nrzi_unstuff #(
  parameter int unsigned RUN_LEN = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic bit_vld_i,
  input  logic bit_i,
  output logic data_vld_o,
  output logic stuff_o,
  output logic err_o
);
  localparam int unsigned CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(RUN_LEN);

  logic [CW-1:0] ones_q;
  logic          full;

  assign full       = (ones_q == RUN_MAX) && !clr_i;
  assign data_vld_o = bit_vld_i && !full;
  assign stuff_o    = bit_vld_i && full && !bit_i;
  assign err_o      = bit_vld_i && full && bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_q <= '0;
    end else if (bit_vld_i) begin
      if (full || !bit_i) ones_q <= '0;
      else                ones_q <= clr_i ? CW'(1) : ones_q + CW'(1);
    end else if (clr_i) begin
      ones_q <= '0;
    end
  end

endmodule

// File: rtl/nrzi_pre_detect.sv
module nrzi_pre_detect #(
  parameter int unsigned        PAT_LEN = 16,
  parameter logic [PAT_LEN-1:0] PATTERN = 16'b0000000100111100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic bit_vld_i,
  input  logic bit_i,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(PAT_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(PAT_LEN - 1);
  localparam logic [CW-1:0] FULL = CW'(PAT_LEN);

  logic [CW-1:0]      cnt_q;
  logic [PAT_LEN-1:0] shr_q;
  logic [CW-1:0]      cnt_eff;
  logic [PAT_LEN-1:0] shr_eff;
  logic [PAT_LEN-1:0] shr_nxt;

  assign cnt_eff = clr_i ? '0 : cnt_q;
  assign shr_eff = clr_i ? '0 : shr_q;
  assign shr_nxt = {shr_eff[PAT_LEN-2:0], bit_i};
  assign hit_o   = bit_vld_i && (cnt_eff == LAST) && (shr_nxt == PATTERN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      shr_q <= '0;
    end else if (bit_vld_i && cnt_eff != FULL) begin
      cnt_q <= cnt_eff + CW'(1);
      shr_q <= shr_nxt;
    end else if (clr_i) begin
      cnt_q <= '0;
      shr_q <= '0;
    end
  end

endmodule

// File: rtl/nrzi_rx_fsm.sv
module nrzi_rx_fsm
  import nrzi_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sym_valid_i,
  input  logic [1:0] sym_i,
  input  logic       data_vld_i,
  input  logic       stuff_err_i,
  input  logic       pre_hit_i,
  output logic       dec_vld_o,
  output logic       dec_bit_o,
  output logic       clr_o,
  output rx_out_t    out_o
);
  rx_state_e state_q, state_base, state_nxt;
  line_sym_e prev_q, prev_nxt;
  line_sym_e sym;
  rx_out_t   out_q, frame_ev, out_nxt;

  assign sym = line_sym_e'(sym_i);

  // symbol-level decode, independent of the bit-level helpers
  always_comb begin
    state_base = state_q;
    prev_nxt   = prev_q;
    dec_vld_o  = 1'b0;
    dec_bit_o  = 1'b0;
    clr_o      = 1'b0;
    frame_ev   = '0;
    if (sym_valid_i) begin
      unique case (state_q)
        ST_WAIT_IDLE: if (sym == SYM_J) state_base = ST_IDLE;
        ST_IDLE: begin
          if (sym == SYM_K) begin
            frame_ev.sop = 1'b1;
            clr_o        = 1'b1;
            dec_vld_o    = 1'b1;
            prev_nxt     = SYM_K;
            state_base   = ST_BITS;
          end else if (sym != SYM_J) begin
            state_base = ST_WAIT_IDLE;
          end
        end
        ST_BITS: begin
          if (sym == SYM_SE0) begin
            state_base = ST_EOP;
          end else if (sym == SYM_SE1) begin
            frame_ev.eop_err = 1'b1;
            state_base       = ST_WAIT_IDLE;
          end else begin
            dec_vld_o = 1'b1;
            dec_bit_o = (sym == prev_q);
            prev_nxt  = sym;
          end
        end
        ST_EOP: begin
          if (sym == SYM_J) begin
            frame_ev.eop = 1'b1;
            state_base   = ST_WAIT_IDLE;
          end else if (sym != SYM_SE0) begin
            frame_ev.eop_err = 1'b1;
            state_base       = ST_WAIT_IDLE;
          end
        end
        default: state_base = ST_WAIT_IDLE;
      endcase
    end
  end

  // merge bit-level results
  always_comb begin
    out_nxt           = frame_ev;
    state_nxt         = state_base;
    out_nxt.data_vld  = data_vld_i;
    out_nxt.data      = data_vld_i && dec_bit_o;
    out_nxt.stuff_err = stuff_err_i;
    out_nxt.pre_req   = pre_hit_i;
    if (stuff_err_i || pre_hit_i) state_nxt = ST_WAIT_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT_IDLE;
      prev_q  <= SYM_J;
      out_q   <= '0;
    end else begin
      state_q <= state_nxt;
      prev_q  <= prev_nxt;
      out_q   <= out_nxt;
    end
  end

  assign out_o = out_q;

endmodule

// File: rtl/nrzi_rx_top.sv
module nrzi_rx_top
  import nrzi_rx_pkg::*;
#(
  parameter int unsigned        RUN_LEN = 6,
  parameter int unsigned        PAT_LEN = 16,
  parameter logic [PAT_LEN-1:0] PATTERN = 16'b0000000100111100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sym_valid_i,
  input  logic [1:0] sym_i,
  output logic       bit_o,
  output logic       bit_valid_o,
  output logic       sop_o,
  output logic       eop_o,
  output logic       stuff_err_o,
  output logic       eop_err_o,
  output logic       pre_req_o
);
  logic    dec_vld, dec_bit, clr;
  logic    data_vld, stuff_bit, stuff_err, pre_hit;
  rx_out_t out;

  nrzi_rx_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sym_valid_i (sym_valid_i),
    .sym_i       (sym_i),
    .data_vld_i  (data_vld),
    .stuff_err_i (stuff_err),
    .pre_hit_i   (pre_hit),
    .dec_vld_o   (dec_vld),
    .dec_bit_o   (dec_bit),
    .clr_o       (clr),
    .out_o       (out)
  );

  nrzi_unstuff #(.RUN_LEN(RUN_LEN)) u_unstuff (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .bit_vld_i  (dec_vld),
    .bit_i      (dec_bit),
    .data_vld_o (data_vld),
    .stuff_o    (stuff_bit),
    .err_o      (stuff_err)
  );

  nrzi_pre_detect #(.PAT_LEN(PAT_LEN), .PATTERN(PATTERN)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .bit_vld_i (data_vld),
    .bit_i     (dec_bit),
    .hit_o     (pre_hit)
  );

  assign bit_o       = out.data;
  assign bit_valid_o = out.data_vld;
  assign sop_o       = out.sop;
  assign eop_o       = out.eop;
  assign stuff_err_o = out.stuff_err;
  assign eop_err_o   = out.eop_err;
  assign pre_req_o   = out.pre_req;

endmodule

// File: rtl/nrzi_rx_chk.sv
module nrzi_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sym_valid_i,
  input logic [1:0] sym_i,
  input logic       bit_o,
  input logic       bit_valid_o,
  input logic       sop_o,
  input logic       eop_o,
  input logic       stuff_err_o,
  input logic       eop_err_o,
  input logic       pre_req_o
);
  AST_SOP_FROM_K: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_o |-> $past(sym_valid_i && sym_i == 2'b10)) else $error("sop"); // R1
  AST_SOP_BIT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_o |-> (bit_valid_o && !bit_o)) else $error("sop bit"); // R2
  AST_STUFF_ERR_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stuff_err_o |-> !bit_valid_o) else $error("stuff err"); // R4
  AST_EOP_FROM_J: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |-> $past(sym_valid_i && sym_i == 2'b01)) else $error("eop"); // R6
  AST_EOP_ERR_SYM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_err_o |-> $past(sym_valid_i && (sym_i == 2'b10 || sym_i == 2'b11))) else $error("eop err"); // R7
  AST_PRE_WITH_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_req_o |-> (bit_valid_o && !bit_o)) else $error("pre"); // R8
  AST_QUIET_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sym_valid_i) |-> !(bit_valid_o || sop_o || eop_o || stuff_err_o || eop_err_o || pre_req_o))
    else $error("quiet"); // R10
  AST_SINGLE_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sop_o, eop_o, stuff_err_o, eop_err_o, pre_req_o})) else $error("events"); // R10
endmodule

bind nrzi_rx_top nrzi_rx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sym_valid_i (sym_valid_i),
  .sym_i       (sym_i),
  .bit_o       (bit_o),
  .bit_valid_o (bit_valid_o),
  .sop_o       (sop_o),
  .eop_o       (eop_o),
  .stuff_err_o (stuff_err_o),
  .eop_err_o   (eop_err_o),
  .pre_req_o   (pre_req_o)
);

// File: tb/nrzi_rx_top_tb_top.sv
module nrzi_rx_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sym_valid = 1'b0;
  logic [1:0] sym = 2'b01;
  logic       bit_o, bit_valid_o, sop_o, eop_o, stuff_err_o, eop_err_o, pre_req_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  localparam logic [1:0] SE0 = 2'b00, J = 2'b01, K = 2'b10, SE1 = 2'b11;

  always #10 clk = ~clk;

  nrzi_rx_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sym_valid_i(sym_valid), .sym_i(sym),
    .bit_o(bit_o), .bit_valid_o(bit_valid_o), .sop_o(sop_o), .eop_o(eop_o),
    .stuff_err_o(stuff_err_o), .eop_err_o(eop_err_o), .pre_req_o(pre_req_o)
  );

  // reference model: 0 wait idle, 1 idle, 2 collecting, 3 in eop
  int         m_state = 0;
  logic [1:0] m_prev = J;
  int         m_ones = 0;
  int         m_nbits = 0;
  logic [15:0] m_pat = '0;
  bit e_bit, e_vld, e_sop, e_eop, e_serr, e_eerr, e_pre;
  logic [1:0] line_sym = J;

  task automatic check(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic deliver(input bit b, input bit first);
    if (first) begin m_ones = 0; m_nbits = 0; m_pat = '0; end
    if (!first && m_ones == 6) begin
      if (b) begin e_serr = 1; m_state = 0; end
      else m_ones = 0;
      return;
    end
    e_vld = 1; e_bit = b;
    m_ones = b ? m_ones + 1 : 0;
    if (m_nbits < 16) begin
      m_pat = {m_pat[14:0], b};
      m_nbits++;
      if (m_nbits == 16 && m_pat == 16'b0000000100111100) begin e_pre = 1; m_state = 0; end
    end
  endtask

  task automatic model(input bit v, input logic [1:0] s);
    {e_bit, e_vld, e_sop, e_eop, e_serr, e_eerr, e_pre} = '0;
    if (!v) return;
    case (m_state)
      0: if (s == J) m_state = 1;
      1: if (s == K) begin e_sop = 1; m_prev = K; m_state = 2; deliver(0, 1); end
         else if (s != J) m_state = 0;
      2: if (s == SE0) m_state = 3;
         else if (s == SE1) begin e_eerr = 1; m_state = 0; end
         else begin
           bit b = (s == m_prev);
           m_prev = s;
           deliver(b, 0);
         end
      default: if (s == J) begin e_eop = 1; m_state = 0; end
               else if (s != SE0) begin e_eerr = 1; m_state = 0; end
    endcase
  endtask

  task automatic compare_all();
    check(sop_o, e_sop, "R1/R9 sop_o");
    check(bit_valid_o, e_vld, "R2/R3/R5/R10 bit_valid_o");
    check(bit_o, e_bit, "R2 bit_o");
    check(stuff_err_o, e_serr, "R4 stuff_err_o");
    check(eop_o, e_eop, "R6 eop_o");
    check(eop_err_o, e_eerr, "R7/R11 eop_err_o");
    check(pre_req_o, e_pre, "R8 pre_req_o");
  endtask

  task automatic step(input bit v, input logic [1:0] s);
    @(negedge clk);
    compare_all();
    model(v, s);
    sym_valid = v;
    sym = s;
  endtask

  // R10: random idle cycles with junk symbols between real ones
  task automatic send(input logic [1:0] s);
    if ($urandom % 4 == 0) step(0, 2'($urandom));
    step(1, s);
    if (s == J || s == K) line_sym = s;
  endtask

  task automatic start_pkt();
    send(J); send(J); send(K);
  endtask

  task automatic send_bits(input bit q[$]);
    foreach (q[i]) begin
      if (!q[i]) line_sym = (line_sym == J) ? K : J;
      send(line_sym);
    end
  endtask

  task automatic end_pkt();
    send(SE0); send(SE0); send(J);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state: all outputs low, waiting for idle
    check(sop_o | bit_valid_o | eop_o | stuff_err_o | eop_err_o | pre_req_o, 0, "R9 reset");
    send(K); // R9: no SOP before J after reset
    // plain packet
    start_pkt(); send_bits('{1,0,1,1,0,0,1,0}); end_pkt();
    // R3 stuff bit removed
    start_pkt(); send_bits('{1,1,1,1,1,1,0,1,0}); end_pkt();
    // R5 zero restarts ones count
    start_pkt(); send_bits('{1,1,1,1,1,0,1,1,1,1,1,1,0,0}); end_pkt();
    // R4 stuff error, then R9 K ignored until J
    start_pkt(); send_bits('{1,1,1,1,1,1,1}); send(K); send(K); send(J); send(K);
    send_bits('{0,1}); end_pkt();
    // R7 bad eop
    start_pkt(); send_bits('{0,1}); send(SE0); send(K); send(J);
    start_pkt(); send_bits('{1}); send(SE0); send(SE1); send(J);
    // R11 SE1 during bits, SE0 while idle
    start_pkt(); send_bits('{0}); send(SE1); send(J); send(SE0); send(K); send(J);
    // R8 preamble pattern
    start_pkt(); send_bits('{0,0,0,0,0,0,1,0,0,1,1,1,1,0,0}); send(K); send(J);
    // near-miss pattern: no request
    start_pkt(); send_bits('{0,0,0,0,0,0,1,0,0,1,1,1,1,0,1,0}); end_pkt();
    // R6 long SE0
    start_pkt(); send_bits('{1,0}); send(SE0); send(SE0); send(SE0); send(SE0); send(J);
    // random traffic
    for (int i = 0; i < 3000; i++) step($urandom % 5 != 0, 2'($urandom % 3 == 0 ? J : $urandom));
    step(0, J);
    step(0, J);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule